// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A request carries the virtual address and three access flags: write, user privilege and instruction fetch. The walker reads the directory entry and then, for a 4 KB page, the table entry, through a memory port that has one request outstanding at a time. It sets the accessed and dirty bits in memory as it goes, combines the permission bits of both levels, and returns either a physical address with its page size or a page-fault error code.

Static configuration inputs select paging on or off, large-page support, supervisor write protection, supervisor fetch protection from user pages, the A20 gate and the directory base. A directory entry can map a 4 MB page whose physical base reaches 40 bits. With paging off, the block returns the virtual address through the A20 mask with no memory traffic.

Entry bit positions used throughout: present = bit 0, writable = bit 1, user = bit 2, accessed = bit 5, dirty = bit 6, large page = bit 7.

The control is one state machine with six states. `S_IDLE` accepts a request and goes to `S_RESP` when paging is off, or to `S_DIR_RD` otherwise. `S_DIR_RD` reads the directory entry. On a fault or a clean large page it goes to `S_RESP`. A large page that needs its flags updated goes to `S_LEAF_WB`. A small-page directory entry whose accessed bit is clear goes to `S_DIR_WB`, and any other small-page entry goes to `S_TBL_RD`. `S_DIR_WB` writes the directory entry back and goes to `S_TBL_RD`. `S_TBL_RD` reads the table entry and goes to `S_LEAF_WB` when the flags need updating, or to `S_RESP` otherwise. `S_LEAF_WB` writes the final entry and goes to `S_RESP`. `S_RESP` raises `done` for one cycle and returns to `S_IDLE`.

Top module: `pgwalk32`

## Requirements
- R1: With `cfg_paging` low, an accepted request completes with `done` in the next cycle, makes no memory access, and returns `pa` = virtual address with bit 20 replaced by `cfg_a20` AND va[20], upper 8 bits zero, `big_page` = 0.
- R2: The directory entry is read from ((`cfg_root` AND 0xFFFFF000) + ((va >> 20) AND 0xFFC)) AND the A20 mask.
- R3: The table entry is read from ((directory entry AND 0xFFFFF000) + ((va >> 10) AND 0xFFC)) AND the A20 mask.
- R4: On a 4 KB walk, a directory entry whose accessed bit (bit 5) is clear is written back with bit 5 set before the table entry is read, even if the walk later faults.
- R5: When the final entry permits the access, the walker writes it back with accessed (bit 5) set and, for a write, dirty (bit 6) set. It writes nothing when both bits already hold those values.
- R6: A directory entry with bit 7 set while `cfg_pse` is high maps a 4 MB page: `pa` = {entry[20:13], entry[31:22], va[21:0]} and `big_page` = 1. If entry bit 21 is set, the walk faults with error bits P and RSVD set.
- R7: A not-present entry (bit 0 clear) at either level ends the walk with `fault` high, error bit P clear, and no writeback of that entry.
- R8: The user and writable permissions are the AND of both levels. A user access without the user permission faults, and a user write without the writable permission faults.
- R9: A supervisor write to a non-writable page faults only when `cfg_wp` is high. A supervisor fetch from a user page faults only when `cfg_smep` is high.
- R10: `err_code` layout: bit 0 P (a violation on a present entry), bit 1 W (access was a write), bit 2 U (access was user), bit 3 RSVD (reserved bit set), bit 4 I/D (a fetch while `cfg_smep` is high).
- R11: The A20 mask (all ones except bit 20, which equals `cfg_a20`) applies to both entry addresses and to the 4 KB frame address.
- R12: `done` is a one-cycle pulse. `req_ready` is low from acceptance until `done`. A memory request holds its address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when `req_ready` is high |
| req_ready | output | 1 | Walker idle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is at user privilege |
| req_fetch | input | 1 | Access is an instruction fetch |
| cfg_paging | input | 1 | Paging enabled |
| cfg_pse | input | 1 | 4 MB directory pages allowed |
| cfg_wp | input | 1 | Supervisor writes obey the writable bit |
| cfg_smep | input | 1 | Supervisor fetches from user pages fault |
| cfg_a20 | input | 1 | A20 gate: value allowed on address bit 20 |
| cfg_root | input | 32 | Page directory base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Entry write data |
| mem_ack | input | 1 | One-cycle completion of the access |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | Result valid for one cycle |
| fault | output | 1 | Walk ended in a page fault |
| err_code | output | 5 | Page-fault error code |
| pa | output | 40 | Physical address |
| big_page | output | 1 | Translation is a 4 MB page |

## Verification
A state machine stuck in or skipping a state shows at the memory port on the next request cycle: a missing or extra write, a read from the wrong entry address, or a missing `done` pulse within a few memory round trips. Corrupted latched entry or access flags show at the result when `done` rises, as a wrong `pa`, wrong page size or wrong error-code bits, or later as wrong accessed and dirty bits in the written-back entry. The bench models the memory, so every read address, every written word and the number of writes in each walk are compared against values computed by hand from the entry bits.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_RD,
        S_DIR_WB,
        S_TBL_RD,
        S_LEAF_WB,
        S_RESP
    } walk_state_t;

    // entry flag positions
    localparam int F_PRES  = 0;
    localparam int F_WR    = 1;
    localparam int F_USR   = 2;
    localparam int F_ACC   = 5;
    localparam int F_DIRTY = 6;
    localparam int F_LARGE = 7;
    localparam int F_RSV4M = 21;

    // error code positions
    localparam int E_P    = 0;
    localparam int E_W    = 1;
    localparam int E_U    = 2;
    localparam int E_RSVD = 3;
    localparam int E_ID   = 4;
    localparam int ERR_W  = 5;

endpackage

// File: rtl/pgw_addr.sv
module pgw_addr #(
    parameter int ADDR_W = 32,
    parameter int PA_W   = 40
) (
    input  logic              a20_gate,
    input  logic [ADDR_W-1:0] root,
    input  logic [ADDR_W-1:0] va,
    input  logic [ADDR_W-1:0] pde,
    input  logic [ADDR_W-1:0] pte,
    output logic [ADDR_W-1:0] dir_addr,
    output logic [ADDR_W-1:0] tbl_addr,
    output logic [PA_W-1:0]   pa_flat,
    output logic [PA_W-1:0]   pa_small,
    output logic [PA_W-1:0]   pa_big
);
    localparam int HI_W = PA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] FRAME_M = 32'hFFFF_F000;
    localparam logic [ADDR_W-1:0] IDX_M   = 32'h0000_0FFC;
    localparam logic [ADDR_W-1:0] LARGE_M = 32'hFFC0_0000;

    logic [ADDR_W-1:0] a20_mask;

    always_comb begin
        a20_mask     = '1;
        a20_mask[20] = a20_gate;
        dir_addr = ((root & FRAME_M) + ((va >> 20) & IDX_M)) & a20_mask;
        tbl_addr = ((pde & FRAME_M) + ((va >> 10) & IDX_M)) & a20_mask;
        pa_flat  = {{HI_W{1'b0}}, va & a20_mask};
        pa_small = {{HI_W{1'b0}}, (pte & a20_mask & FRAME_M) | (va & ~FRAME_M)};
        pa_big   = {pde[13 +: HI_W], (pde & LARGE_M) | (va & ~LARGE_M)};
    end

endmodule

// File: rtl/pgw_perm.sv
module pgw_perm
    import pgw_pkg::*;
(
    input  logic             present,
    input  logic             leaf,
    input  logic             rsvd,
    input  logic             us_ok,
    input  logic             rw_ok,
    input  logic             acc_write,
    input  logic             acc_user,
    input  logic             acc_fetch,
    input  logic             wp_en,
    input  logic             smep_en,
    output logic             fault,
    output logic [ERR_W-1:0] err
);
    logic prot;
    logic viol;

    always_comb begin
        if (acc_user) begin
            prot = !us_ok || (acc_write && !rw_ok);
        end else begin
            prot = (acc_fetch && smep_en && us_ok) ||
                   (acc_write && wp_en && !rw_ok);
        end
        viol        = leaf && (rsvd || prot);
        fault       = !present || viol;
        err         = '0;
        err[E_P]    = present && viol;
        err[E_W]    = acc_write;
        err[E_U]    = acc_user;
        err[E_RSVD] = present && leaf && rsvd;
        err[E_ID]   = acc_fetch && smep_en;
    end

endmodule

// File: rtl/pgwalk32.sv
module pgwalk32
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PA_W   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              req_fetch,
    input  logic              cfg_paging,
    input  logic              cfg_pse,
    input  logic              cfg_wp,
    input  logic              cfg_smep,
    input  logic              cfg_a20,
    input  logic [ADDR_W-1:0] cfg_root,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [ERR_W-1:0]  err_code,
    output logic [PA_W-1:0]   pa,
    output logic              big_page
);
    localparam logic [ADDR_W-1:0] ACC_BIT   = ADDR_W'(1) << F_ACC;
    localparam logic [ADDR_W-1:0] DIRTY_BIT = ADDR_W'(1) << F_DIRTY;

    walk_state_t state, nxt;

    // latched request and walk context
    logic [ADDR_W-1:0] va_q;
    logic              wr_q, usr_q, fch_q;
    logic [ADDR_W-1:0] pde_q;
    logic [ADDR_W-1:0] ent_addr_q;
    logic [ADDR_W-1:0] leaf_q;
    logic              res_fault;
    logic [ERR_W-1:0]  res_err;
    logic [PA_W-1:0]   res_pa;
    logic              res_big;

    // datapath
    logic [ADDR_W-1:0] pde_src;
    logic [ADDR_W-1:0] dir_addr, tbl_addr;
    logic [PA_W-1:0]   pa_flat, pa_small, pa_big;
    logic              in_dir, in_tbl;
    logic              is_big;
    logic              leaf_c, rsvd_c, us_ok_c, rw_ok_c;
    logic              fault_c;
    logic [ERR_W-1:0]  err_c;
    logic [ADDR_W-1:0] upd_entry;
    logic              need_wb;

    assign in_dir  = (state == S_DIR_RD);
    assign in_tbl  = (state == S_TBL_RD);
    assign pde_src = in_dir ? mem_rdata : pde_q;

    pgw_addr #(.ADDR_W(ADDR_W), .PA_W(PA_W)) u_addr (
        .a20_gate (cfg_a20),
        .root     (cfg_root),
        .va       (va_q),
        .pde      (pde_src),
        .pte      (mem_rdata),
        .dir_addr (dir_addr),
        .tbl_addr (tbl_addr),
        .pa_flat  (pa_flat),
        .pa_small (pa_small),
        .pa_big   (pa_big)
    );

    always_comb begin
        is_big    = cfg_pse && mem_rdata[F_LARGE];
        leaf_c    = in_tbl || is_big;
        rsvd_c    = in_dir && is_big && mem_rdata[F_RSV4M];
        us_ok_c   = mem_rdata[F_USR] && (in_tbl ? pde_q[F_USR] : 1'b1);
        rw_ok_c   = mem_rdata[F_WR]  && (in_tbl ? pde_q[F_WR]  : 1'b1);
        upd_entry = mem_rdata | ACC_BIT | (wr_q ? DIRTY_BIT : '0);
        need_wb   = (upd_entry != mem_rdata);
    end

    pgw_perm u_perm (
        .present   (mem_rdata[F_PRES]),
        .leaf      (leaf_c),
        .rsvd      (rsvd_c),
        .us_ok     (us_ok_c),
        .rw_ok     (rw_ok_c),
        .acc_write (wr_q),
        .acc_user  (usr_q),
        .acc_fetch (fch_q),
        .wp_en     (cfg_wp),
        .smep_en   (cfg_smep),
        .fault     (fault_c),
        .err       (err_c)
    );

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) nxt = cfg_paging ? S_DIR_RD : S_RESP;
            end
            S_DIR_RD: begin
                if (mem_ack) begin
                    if (fault_c)                nxt = S_RESP;
                    else if (is_big)            nxt = need_wb ? S_LEAF_WB : S_RESP;
                    else if (!mem_rdata[F_ACC]) nxt = S_DIR_WB;
                    else                        nxt = S_TBL_RD;
                end
            end
            S_DIR_WB: begin
                if (mem_ack) nxt = S_TBL_RD;
            end
            S_TBL_RD: begin
                if (mem_ack) begin
                    if (fault_c)      nxt = S_RESP;
                    else if (need_wb) nxt = S_LEAF_WB;
                    else              nxt = S_RESP;
                end
            end
            S_LEAF_WB: begin
                if (mem_ack) nxt = S_RESP;
            end
            S_RESP:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // walk context capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q       <= '0;
            wr_q       <= 1'b0;
            usr_q      <= 1'b0;
            fch_q      <= 1'b0;
            pde_q      <= '0;
            ent_addr_q <= '0;
            leaf_q     <= '0;
            res_fault  <= 1'b0;
            res_err    <= '0;
            res_pa     <= '0;
            res_big    <= 1'b0;
        end else begin
            if (state == S_IDLE && req_valid) begin
                va_q      <= req_va;
                wr_q      <= req_write;
                usr_q     <= req_user;
                fch_q     <= req_fetch;
                res_fault <= 1'b0;
                res_err   <= '0;
                res_big   <= 1'b0;
                res_pa    <= {{(PA_W-ADDR_W){1'b0}}, req_va & {{(ADDR_W-21){1'b1}}, cfg_a20, 20'hFFFFF}};
            end
            if (in_dir && mem_ack) begin
                pde_q      <= mem_rdata;
                ent_addr_q <= dir_addr;
                leaf_q     <= upd_entry;
                res_fault  <= fault_c;
                res_err    <= err_c;
                res_big    <= is_big;
                res_pa     <= pa_big;
            end
            if (in_tbl && mem_ack) begin
                ent_addr_q <= tbl_addr;
                leaf_q     <= upd_entry;
                res_fault  <= fault_c;
                res_err    <= err_c;
                res_big    <= 1'b0;
                res_pa     <= pa_small;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        unique case (state)
            S_IDLE:   req_ready = 1'b1;
            S_DIR_RD: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
            end
            S_DIR_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ent_addr_q;
                mem_wdata = pde_q | ACC_BIT;
            end
            S_TBL_RD: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
            end
            S_LEAF_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ent_addr_q;
                mem_wdata = leaf_q;
            end
            S_RESP:  done = 1'b1;
            default: ;
        endcase
        fault    = done && res_fault;
        err_code = done ? res_err : '0;
        pa       = done ? res_pa  : '0;
        big_page = done && res_big;
    end

    // pa_flat is the registered identity path's combinational twin; kept observable
    logic unused_flat;
    assign unused_flat = ^pa_flat;

endmodule

// File: rtl/pgw_chk.sv
module pgw_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        cfg_paging,
    input logic        cfg_smep,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        done,
    input logic        fault,
    input logic [4:0]  err_code
);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r5_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[5]);

    a_r6_rsvd_present: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_code[3] |-> err_code[0] && fault);

    a_r10_id_smep: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_code[4] |-> cfg_smep);

    a_r1_flat_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_paging && req_valid && req_ready |=> done && !mem_req);

    a_r7_p_implies_fault: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_code[0] |-> fault);

endmodule

bind pgwalk32 pgw_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .cfg_paging (cfg_paging),
    .cfg_smep   (cfg_smep),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .done       (done),
    .fault      (fault),
    .err_code   (err_code)
);

// File: tb/sim_pgwalk32.sv
`timescale 1ns/1ps
module sim_pgwalk32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0;
    logic        cfg_paging = 1'b1, cfg_pse = 1'b1, cfg_wp = 1'b1;
    logic        cfg_smep = 1'b1, cfg_a20 = 1'b1;
    logic [31:0] cfg_root = 32'h0000_1000;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, fault, big_page;
    logic [4:0]  err_code;
    logic [39:0] pa;

    always #4 clk = ~clk;

    pgwalk32 u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
        .cfg_paging(cfg_paging), .cfg_pse(cfg_pse), .cfg_wp(cfg_wp), .cfg_smep(cfg_smep),
        .cfg_a20(cfg_a20), .cfg_root(cfg_root),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .err_code(err_code), .pa(pa), .big_page(big_page)
    );

    // memory model
    logic [31:0] mem [logic [31:0]];
    int          wr_cnt, rd_cnt;
    logic [31:0] first_addr, last_rd;
    logic        first_set;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                rd_cnt  = rd_cnt + 1;
                last_rd = mem_addr;
            end
            if (!first_set) begin
                first_addr = mem_addr;
                first_set  = 1'b1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    logic        g_fault, g_big, g_done_after, g_busy;
    logic [4:0]  g_err;
    logic [39:0] g_pa;

    task automatic walk(input logic [31:0] va, input logic w, input logic u, input logic f);
        @(negedge clk);
        wr_cnt = 0; rd_cnt = 0; first_set = 1'b0;
        req_va = va; req_write = w; req_user = u; req_fetch = f;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        g_busy = !req_ready;
        for (int i = 0; i < 64 && !done; i++) @(negedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R12: walk timeout got done=0 expected 1");
        end
        g_fault = fault; g_err = err_code; g_pa = pa; g_big = big_page;
        @(negedge clk);
        g_done_after = done;
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        w, u, f;
        logic        xf;
        logic [4:0]  xe;
        logic [39:0] xpa;
        logic        xbig;
        logic [1:0]  xwr;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{32'h0000_1234, 1'b0, 1'b1, 1'b0, 1'b0, 5'h00, 40'h00_0005_5234, 1'b0, 2'd2},
        '{32'h0000_1238, 1'b1, 1'b1, 1'b0, 1'b0, 5'h00, 40'h00_0005_5238, 1'b0, 2'd1},
        '{32'h0000_1000, 1'b0, 1'b1, 1'b0, 1'b0, 5'h00, 40'h00_0005_5000, 1'b0, 2'd0},
        '{32'h0000_2010, 1'b1, 1'b1, 1'b0, 1'b1, 5'h07, 40'h0,            1'b0, 2'd0},
        '{32'h0000_2010, 1'b0, 1'b1, 1'b0, 1'b0, 5'h00, 40'h00_0006_6010, 1'b0, 2'd1},
        '{32'h0000_3000, 1'b0, 1'b1, 1'b0, 1'b1, 5'h04, 40'h0,            1'b0, 2'd0},
        '{32'h0000_4abc, 1'b0, 1'b1, 1'b0, 1'b1, 5'h05, 40'h0,            1'b0, 2'd0},
        '{32'h0000_4abc, 1'b1, 1'b0, 1'b0, 1'b0, 5'h00, 40'h00_0008_8abc, 1'b0, 2'd1},
        '{32'h0000_5000, 1'b1, 1'b0, 1'b0, 1'b1, 5'h03, 40'h0,            1'b0, 2'd0},
        '{32'h0000_5000, 1'b0, 1'b0, 1'b1, 1'b1, 5'h11, 40'h0,            1'b0, 2'd0},
        '{32'h0000_5004, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00, 40'h00_0009_9004, 1'b0, 2'd0},
        '{32'h0045_6789, 1'b0, 1'b1, 1'b0, 1'b0, 5'h00, 40'h01_0C45_6789, 1'b1, 2'd0},
        '{32'h0080_0000, 1'b1, 1'b1, 1'b0, 1'b1, 5'h0F, 40'h0,            1'b0, 2'd0},
        '{32'h00C0_0010, 1'b0, 1'b1, 1'b1, 1'b1, 5'h14, 40'h0,            1'b0, 2'd0},
        '{32'h0100_0000, 1'b0, 1'b1, 1'b0, 1'b1, 5'h05, 40'h0,            1'b0, 2'd1},
        '{32'h0100_0000, 1'b0, 1'b0, 1'b0, 1'b0, 5'h00, 40'h00_000A_A000, 1'b0, 2'd1}
    };

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R12: watchdog expired got running expected finished");
        summary();
    end

    initial begin
        wr_cnt = 0; rd_cnt = 0; first_set = 1'b0; first_addr = '0; last_rd = '0;
        // directory at 0x1000
        mem[32'h1000] = 32'h0000_2007;   // small, user rw, not accessed
        mem[32'h1004] = 32'h0C40_20E7;   // 4 MB, hi bits 0x01
        mem[32'h1008] = 32'h0060_0083;   // 4 MB with bit 21 set
        mem[32'h100C] = 32'h0000_0000;   // not present
        mem[32'h1010] = 32'h0000_3003;   // supervisor-only table
        // table at 0x2000
        mem[32'h2004] = 32'h0005_5007;
        mem[32'h2008] = 32'h0006_6005;
        mem[32'h200C] = 32'h0007_7000;
        mem[32'h2010] = 32'h0008_8023;
        mem[32'h2014] = 32'h0009_9065;
        mem[32'h2018] = 32'h0017_7067;
        mem[32'h3000] = 32'h000A_A007;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 reset req_ready", {63'b0, req_ready}, 64'd1);
        chk("R12 reset done", {63'b0, done}, 64'd0);
        chk("R12 reset mem_req", {63'b0, mem_req}, 64'd0);
        rst_n = 1'b1;

        for (int k = 0; k < 16; k++) begin
            walk(VECS[k].va, VECS[k].w, VECS[k].u, VECS[k].f);
            // R7 R8 R9 R10 R6: fault and error code
            chk($sformatf("R8/R10 vec%0d fault", k), {63'b0, g_fault}, {63'b0, VECS[k].xf});
            if (VECS[k].xf) begin
                chk($sformatf("R10 vec%0d err", k), {59'b0, g_err}, {59'b0, VECS[k].xe});
            end else begin
                chk($sformatf("R6 vec%0d pa", k), {24'b0, g_pa}, {24'b0, VECS[k].xpa});
                chk($sformatf("R6 vec%0d big", k), {63'b0, g_big}, {63'b0, VECS[k].xbig});
            end
            chk($sformatf("R5/R4 vec%0d writes", k), 64'(wr_cnt), 64'(VECS[k].xwr));
        end

        // memory contents after writebacks
        chk("R4 pde accessed", {32'b0, mem[32'h1000]}, 64'h0000_2027);
        chk("R5 pte dirty", {32'b0, mem[32'h2004]}, 64'h0005_5067);
        chk("R4 pde accessed on fault walk", {32'b0, mem[32'h1010]}, 64'h0000_3023);
        chk("R7 no writeback after fault", {32'b0, mem[32'h2008]}, 64'h0006_6025);

        // R2 directory address
        walk(32'h0045_6789, 1'b0, 1'b1, 1'b0);
        chk("R2 dir addr", {32'b0, first_addr}, 64'h0000_1004);
        chk("R12 done one cycle", {63'b0, g_done_after}, 64'd0);
        chk("R12 busy during walk", {63'b0, g_busy}, 64'd1);

        // R3 table address with large pages off
        cfg_pse = 1'b0;
        walk(32'h0045_6789, 1'b0, 1'b1, 1'b0);
        chk("R3 tbl addr", {32'b0, last_rd}, 64'h0C40_2158);
        chk("R7 not present err", {59'b0, g_err}, 64'h04);
        chk("R7 no write", 64'(wr_cnt), 64'd0);
        cfg_pse = 1'b1;

        // R9 write protect off
        cfg_wp = 1'b0;
        walk(32'h0000_5000, 1'b1, 1'b0, 1'b0);
        chk("R9 wp off fault", {63'b0, g_fault}, 64'd0);
        chk("R9 wp off pa", {24'b0, g_pa}, 64'h0009_9000);
        cfg_wp = 1'b1;

        // R9/R10 SMEP off
        cfg_smep = 1'b0;
        walk(32'h0000_5000, 1'b0, 1'b0, 1'b1);
        chk("R9 smep off fault", {63'b0, g_fault}, 64'd0);
        walk(32'h00C0_0010, 1'b0, 1'b1, 1'b1);
        chk("R10 no I/D without smep", {59'b0, g_err}, 64'h04);
        cfg_smep = 1'b1;

        // R11 A20 on entry addresses and frame
        cfg_a20 = 1'b0;
        cfg_root = 32'h0010_1000;
        walk(32'h0000_6abc, 1'b0, 1'b1, 1'b0);
        chk("R11 dir addr masked", {32'b0, first_addr}, 64'h0000_1000);
        chk("R11 frame masked", {24'b0, g_pa}, 64'h0007_7abc);
        cfg_a20 = 1'b1;
        cfg_root = 32'h0000_1000;
        walk(32'h0000_6abc, 1'b0, 1'b1, 1'b0);
        chk("R11 frame unmasked", {24'b0, g_pa}, 64'h0017_7abc);

        // R1 paging off
        cfg_paging = 1'b0;
        cfg_a20 = 1'b0;
        walk(32'h0012_3456, 1'b1, 1'b1, 1'b0);
        chk("R1 flat pa a20 low", {24'b0, g_pa}, 64'h0002_3456);
        chk("R1 no memory access", 64'(rd_cnt + wr_cnt), 64'd0);
        chk("R1 no fault", {63'b0, g_fault}, 64'd0);
        cfg_a20 = 1'b1;
        walk(32'h0012_3456, 1'b0, 1'b0, 1'b0);
        chk("R1 flat pa a20 high", {24'b0, g_pa}, 64'h0012_3456);
        chk("R1 small page", {63'b0, g_big}, 64'd0);

        summary();
    end

endmodule